// File: doc/BRIEF.md
# Multi-Scheme Character Bank Mapper

This block translates a 13-bit pattern-table address from the picture processor into a character-ROM byte address. It supports three banking schemes picked by the low two bits of a mode byte: a direct scheme with eight independent 1 KB windows, an indexed scheme with two 2 KB pairs, four 1 KB windows and an optional exchange of the two 4 KB pattern halves, and a serial scheme that maps either two 4 KB banks or one 8 KB bank.

A multicart game index places every bank inside an outer region. A non-zero index narrows the inner bank mask to seven bits and supplies an outer base. In the two 1 KB schemes a further mode bit raises the base by 256 banks. The register files and control bytes come from the surrounding register logic. The mapped address is registered, so it appears one clock after its inputs.

Top module: `chr_bank_map`

## Requirements
- R1: While rst_ni is low, chr_addr_o is zero.
- R2: chr_addr_o is the mapping of the inputs sampled at the previous rising clock edge. Byte offset bits [9:0] always pass through from ppu_addr_i.
- R3: With game_i equal to 0, the inner mask is 0xFF and the outer base is 0. With game_i equal to n (n non-zero), the inner mask is 0x7F and the outer base is (n+1)*0x80. Each bank equals (high base & ~mask) | (register & mask).
- R4: With mode_i[1:0]=0, window w (ppu_addr_i[12:10]) uses direct register w (direct_regs_i[8w+7:8w]) as its 1 KB bank.
- R5: With mode_i[1:0]=1 and idx_ctrl_i[7]=0, windows 0/1 use index register 0 with bit 0 forced to 0/1. Windows 2/3 use register 1 the same way. Windows 4..7 use registers 2..5 (idx_regs_i[8r+7:8r]).
- R6: With mode_i[1:0]=1 and idx_ctrl_i[7]=1, the window number is XORed with 4, which exchanges the two 4 KB halves.
- R7: In the 1 KB schemes, mode_i[2]=1 ORs 256 banks into the high base before the mask is applied.
- R8: With mode_i[1]=1 and ser_ctrl_i[4]=1, the lower 4 KB half uses serial register 1 (ser_regs_i[7:0]) and the upper half uses register 2 (ser_regs_i[15:8]). The byte address is bank*4096 + ppu_addr_i[11:0].
- R9: With mode_i[1]=1 and ser_ctrl_i[4]=0, the 8 KB bank is ((outer & ~mask)>>1) | ((register 1 & mask)>>1). The byte address is bank*8192 + ppu_addr_i.
- R10: mode_i[7:3] has no effect on the output, and mode_i[2] has no effect in the serial scheme.
- R11: mode_i[1:0]=3 maps exactly as mode_i[1:0]=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ppu_addr_i | input | 13 | Pattern-table address |
| mode_i | input | REG_W (8) | Scheme in [1:0], 256-bank base in [2] |
| direct_regs_i | input | 8*REG_W (64) | Direct-scheme registers 0..7, register i at [8i+7:8i] |
| idx_regs_i | input | 6*REG_W (48) | Indexed-scheme registers 0..5 |
| idx_ctrl_i | input | REG_W (8) | Indexed control, bit 7 swaps the halves |
| ser_ctrl_i | input | REG_W (8) | Serial control, bit 4 selects 4 KB banking |
| ser_regs_i | input | 2*REG_W (16) | Serial registers 1 (low byte) and 2 (high byte) |
| game_i | input | GAME_W (3) | Multicart game index |
| chr_addr_o | output | REG_W+GAME_W+12 (23) | Registered character-ROM byte address |

## Verification
The bench targets three corner cases. The first is the pair forcing in the indexed scheme: if bit 0 is not overwritten, odd windows read the wrong 1 KB half of a pair. The second is the half swap: a design that swaps in the wrong scheme, or XORs the wrong window bit, maps the upper and lower 4 KB of pattern space onto the wrong registers. The third is where the mask and bases apply. If the 256-bank base leaks into the serial scheme, mode values that should match produce different addresses. If the mask is missing for non-zero game indices, inner register bit 7 corrupts the outer region. If the 8 KB outer term is not shifted, the address lands twice as far out.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;
  localparam int PPU_AW     = 13;
  localparam int WIN_COUNT  = 8;
  localparam int IDX_COUNT  = 6;
  localparam int BASE_BIT   = 2;
  localparam int SWAP_BIT   = 7;
  localparam int SPLIT_BIT  = 4;

  typedef enum logic [1:0] {
    SCH_DIRECT  = 2'd0,
    SCH_INDEXED = 2'd1,
    SCH_SER_A   = 2'd2,
    SCH_SER_B   = 2'd3
  } scheme_e;
endpackage

// File: rtl/chr_outer_gen.sv
module chr_outer_gen #(
  parameter int REG_W  = 8,
  parameter int GAME_W = 3,
  localparam int BANK_W = REG_W + GAME_W
) (
  input  logic [GAME_W-1:0] game_i,
  output logic [BANK_W-1:0] mask_o,
  output logic [BANK_W-1:0] outer_o
);
  always_comb begin
    mask_o             = '0;
    mask_o[REG_W-1:0]  = '1;
    outer_o            = '0;
    if (game_i != '0) begin
      mask_o[REG_W-1] = 1'b0;
      outer_o = BANK_W'({1'b0, game_i} + (GAME_W+1)'(1)) << (REG_W - 1);
    end
  end
endmodule

// File: rtl/chr_fine_sel.sv
module chr_fine_sel import chr_map_pkg::*; #(
  parameter int REG_W = 8
) (
  input  logic [2:0]                 win_i,
  input  logic                       indexed_i,
  input  logic                       swap_i,
  input  logic [WIN_COUNT*REG_W-1:0] direct_regs_i,
  input  logic [IDX_COUNT*REG_W-1:0] idx_regs_i,
  output logic [REG_W-1:0]           reg_o
);
  logic [REG_W-1:0] dir_a [WIN_COUNT];
  logic [REG_W-1:0] idx_a [IDX_COUNT];

  for (genvar i = 0; i < WIN_COUNT; i++) begin : g_dir
    assign dir_a[i] = direct_regs_i[i*REG_W +: REG_W];
  end
  for (genvar i = 0; i < IDX_COUNT; i++) begin : g_idx
    assign idx_a[i] = idx_regs_i[i*REG_W +: REG_W];
  end

  logic [2:0] k;
  assign k = win_i ^ {swap_i, 2'b00};

  always_comb begin
    if (!indexed_i)
      reg_o = dir_a[win_i];
    else if (!k[2])
      // 2 KB pair: low bit comes from the window, not the register
      reg_o = {idx_a[{2'b00, k[1]}][REG_W-1:1], k[0]};
    else
      reg_o = idx_a[3'd2 + {1'b0, k[1:0]}];
  end
endmodule

// File: rtl/chr_coarse_sel.sv
module chr_coarse_sel import chr_map_pkg::*; #(
  parameter int REG_W  = 8,
  parameter int GAME_W = 3,
  localparam int BANK_W = REG_W + GAME_W,
  localparam int CHR_AW = BANK_W + 12
) (
  input  logic [PPU_AW-1:0] ppu_i,
  input  logic              split_i,
  input  logic [REG_W-1:0]  reg1_i,
  input  logic [REG_W-1:0]  reg2_i,
  input  logic [BANK_W-1:0] mask_i,
  input  logic [BANK_W-1:0] outer_i,
  output logic [CHR_AW-1:0] addr_o
);
  logic [BANK_W-1:0] outer_hi, sel, b4, b8;
  logic              unused_b8;

  assign outer_hi  = outer_i & ~mask_i;
  assign sel       = BANK_W'(ppu_i[12] ? reg2_i : reg1_i);
  assign b4        = outer_hi | (sel & mask_i);
  assign b8        = (outer_hi >> 1) | ((BANK_W'(reg1_i) & mask_i) >> 1);
  assign unused_b8 = b8[BANK_W-1];

  always_comb begin
    if (split_i) addr_o = {b4, ppu_i[11:0]};
    else         addr_o = {b8[BANK_W-2:0], ppu_i};
  end
endmodule

// File: rtl/chr_bank_map.sv
module chr_bank_map import chr_map_pkg::*; #(
  parameter int REG_W  = 8,
  parameter int GAME_W = 3,
  localparam int BANK_W = REG_W + GAME_W,
  localparam int CHR_AW = BANK_W + 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [PPU_AW-1:0]          ppu_addr_i,
  input  logic [REG_W-1:0]           mode_i,
  input  logic [WIN_COUNT*REG_W-1:0] direct_regs_i,
  input  logic [IDX_COUNT*REG_W-1:0] idx_regs_i,
  input  logic [REG_W-1:0]           idx_ctrl_i,
  input  logic [REG_W-1:0]           ser_ctrl_i,
  input  logic [2*REG_W-1:0]         ser_regs_i,
  input  logic [GAME_W-1:0]          game_i,
  output logic [CHR_AW-1:0]          chr_addr_o
);
  scheme_e           scheme;
  logic [BANK_W-1:0] mask, outer, base, fine_hi, bank1;
  logic [REG_W-1:0]  fine_reg;
  logic [CHR_AW-1:0] addr_fine, addr_coarse, addr_d;
  logic              unused_bits;

  assign scheme = scheme_e'(mode_i[1:0]);
  assign unused_bits = ^{mode_i[REG_W-1:3], idx_ctrl_i[REG_W-2:0],
                         ser_ctrl_i[REG_W-1:SPLIT_BIT+1], ser_ctrl_i[SPLIT_BIT-1:0]};

  chr_outer_gen #(.REG_W(REG_W), .GAME_W(GAME_W)) u_outer (
    .game_i  (game_i),
    .mask_o  (mask),
    .outer_o (outer)
  );

  chr_fine_sel #(.REG_W(REG_W)) u_fine (
    .win_i         (ppu_addr_i[12:10]),
    .indexed_i     (scheme == SCH_INDEXED),
    .swap_i        (idx_ctrl_i[SWAP_BIT]),
    .direct_regs_i (direct_regs_i),
    .idx_regs_i    (idx_regs_i),
    .reg_o         (fine_reg)
  );

  chr_coarse_sel #(.REG_W(REG_W), .GAME_W(GAME_W)) u_coarse (
    .ppu_i   (ppu_addr_i),
    .split_i (ser_ctrl_i[SPLIT_BIT]),
    .reg1_i  (ser_regs_i[REG_W-1:0]),
    .reg2_i  (ser_regs_i[2*REG_W-1:REG_W]),
    .mask_i  (mask),
    .outer_i (outer),
    .addr_o  (addr_coarse)
  );

  // 256-bank base only applies to the 1 KB schemes
  assign base      = mode_i[BASE_BIT] ? (BANK_W'(1) << REG_W) : '0;
  assign fine_hi   = (outer | base) & ~mask;
  assign bank1     = fine_hi | (BANK_W'(fine_reg) & mask);
  assign addr_fine = {2'b00, bank1, ppu_addr_i[9:0]};

  always_comb begin
    unique case (scheme)
      SCH_DIRECT, SCH_INDEXED: addr_d = addr_fine;
      default:                 addr_d = addr_coarse;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chr_addr_o <= '0;
    else         chr_addr_o <= addr_d;
  end
endmodule

// File: rtl/chr_bank_map_chk.sv
module chr_bank_map_chk #(
  parameter int REG_W  = 8,
  parameter int GAME_W = 3,
  localparam int BANK_W = REG_W + GAME_W,
  localparam int CHR_AW = BANK_W + 12
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [12:0]          ppu_addr_i,
  input logic [REG_W-1:0]     mode_i,
  input logic [8*REG_W-1:0]   direct_regs_i,
  input logic [REG_W-1:0]     ser_ctrl_i,
  input logic [GAME_W-1:0]    game_i,
  input logic [CHR_AW-1:0]    chr_addr_o
);
  logic             valid_q;
  logic [REG_W-1:0] dir_sel;
  logic [GAME_W+2:0] outer_exp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= 1'b1;
  end

  assign dir_sel   = direct_regs_i[ppu_addr_i[12:10]*REG_W +: REG_W];
  assign outer_exp = ({3'b000, game_i} + (GAME_W+3)'(1)) | (GAME_W+3)'({mode_i[2], 1'b0});

  assert_reset_zero_R1: assert property (@(posedge clk_i)
    !rst_ni |-> chr_addr_o == '0);

  assert_offset_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> chr_addr_o[9:0] == $past(ppu_addr_i[9:0]));

  assert_outer_region_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && $past(mode_i[1] == 1'b0 && game_i != '0)
    |-> chr_addr_o[CHR_AW-1:REG_W+9] == $past(outer_exp));

  assert_direct_bank_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && $past(mode_i[1:0] == 2'd0 && !mode_i[2] && game_i == '0)
    |-> chr_addr_o[REG_W+9:10] == $past(dir_sel));

  assert_split_offset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && $past(mode_i[1] && ser_ctrl_i[4])
    |-> chr_addr_o[11:0] == $past(ppu_addr_i[11:0]));

  assert_whole_offset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && $past(mode_i[1] && !ser_ctrl_i[4])
    |-> chr_addr_o[12:0] == $past(ppu_addr_i));
endmodule

bind chr_bank_map chr_bank_map_chk #(.REG_W(REG_W), .GAME_W(GAME_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ppu_addr_i    (ppu_addr_i),
  .mode_i        (mode_i),
  .direct_regs_i (direct_regs_i),
  .ser_ctrl_i    (ser_ctrl_i),
  .game_i        (game_i),
  .chr_addr_o    (chr_addr_o)
);

// File: tb/tb_chr_bank_map.sv
module tb_chr_bank_map;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic [12:0] ppu_addr_i = '0;
  logic [7:0]  mode_i = '0;
  logic [7:0]  idx_ctrl_i = '0;
  logic [7:0]  ser_ctrl_i = '0;
  logic [2:0]  game_i = '0;
  logic [7:0]  dreg [8];
  logic [7:0]  ireg [6];
  logic [7:0]  sreg1 = '0, sreg2 = '0;
  logic [63:0] direct_regs_i;
  logic [47:0] idx_regs_i;
  logic [15:0] ser_regs_i;
  logic [22:0] chr_addr_o;

  int errors = 0;
  int checks = 0;

  always #10 clk_i = ~clk_i;

  always_comb begin
    for (int i = 0; i < 8; i++) direct_regs_i[i*8 +: 8] = dreg[i];
    for (int i = 0; i < 6; i++) idx_regs_i[i*8 +: 8] = ireg[i];
    ser_regs_i = {sreg2, sreg1};
  end

  chr_bank_map dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ppu_addr_i(ppu_addr_i), .mode_i(mode_i),
    .direct_regs_i(direct_regs_i), .idx_regs_i(idx_regs_i), .idx_ctrl_i(idx_ctrl_i),
    .ser_ctrl_i(ser_ctrl_i), .ser_regs_i(ser_regs_i), .game_i(game_i),
    .chr_addr_o(chr_addr_o)
  );

  function automatic int ref_addr();
    int g = int'(game_i);
    int mask = (g != 0) ? 127 : 255;
    int outer = (g != 0) ? (g + 1) * 128 : 0;
    int base = mode_i[2] ? 256 : 0;
    int w = int'(ppu_addr_i) / 1024;
    int r, bank, k;
    case (mode_i[1:0])
      2'd0: begin
        bank = ((outer | base) & ~mask) | (int'(dreg[w]) & mask);
        return bank * 1024 + int'(ppu_addr_i) % 1024;
      end
      2'd1: begin
        k = idx_ctrl_i[7] ? (w ^ 4) : w;
        if (k < 4) r = (k % 2 == 1) ? (int'(ireg[k/2]) | 1) : (int'(ireg[k/2]) & 254);
        else       r = int'(ireg[k-2]);
        bank = ((outer | base) & ~mask) | (r & mask);
        return bank * 1024 + int'(ppu_addr_i) % 1024;
      end
      default: begin
        if (ser_ctrl_i[4]) begin
          r = (w < 4) ? int'(sreg1) : int'(sreg2);
          bank = (outer & ~mask) | (r & mask);
          return bank * 4096 + int'(ppu_addr_i) % 4096;
        end
        bank = ((outer & ~mask) / 2) | ((int'(sreg1) & mask) / 2);
        return bank * 8192 + int'(ppu_addr_i);
      end
    endcase
  endfunction

  task automatic cmp(string tag, int exp);
    checks++;
    if (int'(chr_addr_o) != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, chr_addr_o, exp);
    end
  endtask

  // inputs already driven; wait for the capturing edge and check
  task automatic step_check(string tag);
    @(posedge clk_i); #1;
    cmp(tag, ref_addr());
  endtask

  task automatic drive_at_negedge();
    @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int e1, e2;
    string tag;
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) dreg[i] = 8'hFF;
    for (int i = 0; i < 6; i++) ireg[i] = 8'hFF;
    mode_i = 8'h01;
    #1 rst_ni = 1'b0;
    @(posedge clk_i); #1;
    cmp("R1", 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R3: game 2, direct window 3
    mode_i = 8'h00; game_i = 3'd2; dreg[3] = 8'hA5; ppu_addr_i = 13'h0C12;
    @(posedge clk_i); #1; cmp("R3", 32'h69412);
    // R7: game 0, 256-bank base
    @(negedge clk_i); mode_i = 8'h04; game_i = 3'd0;
    @(posedge clk_i); #1; cmp("R7", 32'h69412);
    // R2: new inputs not visible before the edge
    @(negedge clk_i); ppu_addr_i = 13'h0000; dreg[0] = 8'h11; mode_i = 8'h00;
    #1 cmp("R2", 32'h69412);
    @(posedge clk_i); #1; cmp("R2", 32'h11 * 1024);
    // R5 pairs
    @(negedge clk_i); mode_i = 8'h01; idx_ctrl_i = 8'h00; ireg[0] = 8'h37; ppu_addr_i = 13'h0400;
    @(posedge clk_i); #1; cmp("R5", 32'hDC00);
    @(negedge clk_i); ppu_addr_i = 13'h0000;
    @(posedge clk_i); #1; cmp("R5", 32'hD800);
    // R6 swap
    @(negedge clk_i); idx_ctrl_i = 8'h80; ppu_addr_i = 13'h1000;
    @(posedge clk_i); #1; cmp("R6", 32'hD800);
    // R8 / R9
    @(negedge clk_i); mode_i = 8'h02; ser_ctrl_i = 8'h10; sreg1 = 8'h05; sreg2 = 8'h09;
    ppu_addr_i = 13'h1234;
    @(posedge clk_i); #1; cmp("R8", 32'h9234);
    @(negedge clk_i); ser_ctrl_i = 8'h00;
    @(posedge clk_i); #1; cmp("R9", 32'h5234);

    // R10 / R11 equivalences across all games
    for (int g = 0; g < 8; g++) begin
      @(negedge clk_i); game_i = 3'(g); ser_ctrl_i = 8'($urandom) & 8'h10;
      sreg1 = 8'($urandom); sreg2 = 8'($urandom); ppu_addr_i = 13'($urandom);
      for (int i = 0; i < 8; i++) dreg[i] = 8'($urandom);
      mode_i = 8'h02;
      @(posedge clk_i); #1; e1 = int'(chr_addr_o);
      @(negedge clk_i); mode_i = 8'h06;
      @(posedge clk_i); #1; cmp("R10", e1);
      @(negedge clk_i); mode_i = 8'h03;
      @(posedge clk_i); #1; cmp("R11", e1);
      @(negedge clk_i); mode_i = 8'h00;
      @(posedge clk_i); #1; e2 = int'(chr_addr_o);
      @(negedge clk_i); mode_i = 8'hF8;
      @(posedge clk_i); #1; cmp("R10", e2);
    end

    // random sweep over schemes, swap settings and game indices
    for (int n = 0; n < 600; n++) begin
      @(negedge clk_i);
      game_i = 3'(n % 8);
      mode_i = 8'($urandom);
      idx_ctrl_i = 8'($urandom);
      ser_ctrl_i = 8'($urandom);
      sreg1 = 8'($urandom); sreg2 = 8'($urandom);
      ppu_addr_i = 13'($urandom);
      for (int i = 0; i < 8; i++) dreg[i] = 8'($urandom);
      for (int i = 0; i < 6; i++) ireg[i] = 8'($urandom);
      case (mode_i[1:0])
        2'd0:    tag = (game_i != 0) ? "R3" : "R4";
        2'd1:    tag = idx_ctrl_i[7] ? "R6" : "R5";
        default: tag = ser_ctrl_i[4] ? "R8" : "R9";
      endcase
      step_check(tag);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule